// File: doc/BRIEF.md
# Command-Driven Coin and Input Controller

This block answers a host CPU on a single 8-bit I/O port in place of a small microcontroller. The CPU first writes a command byte. That byte sets what the next reads return: either player controls, the raw coin switch levels, half of the DIP switch bank, or the credit count. The block also keeps a coin-to-credit ledger. The coinage for each coin slot comes from two DIP switch bits, and credits stop at a ceiling of nine.

Reading with the credit command is what advances the ledger. On that read the block samples both coin switches and compares them with the sample taken at the previous credit read. A qualifying change counts one coin, may convert coins to credits, and raises a one-clock pulse for that slot's mechanical counter. Two other commands clear the ledger or take one credit away; reads under those commands return 0xFF.

The latched command is held as a decoded state. The states are NONE, P1, P2, COINRAW, CREDIT, CLEAR, DEC, DIPLO and DIPHI. Every write moves the state to the one its byte decodes to; any byte that is not a known command goes to NONE. Reset puts the state in NONE. Without a write the state does not change, so a command stays in force for any number of reads.

Top module: `coin_io_ctrl`

## Requirements
- R1: A write (wr_en high) latches the command byte. Under 0x81 a read returns {0, p1_n[6:0]}, and under 0x82 it returns {0, p2_n[6:0]}.
- R2: Under 0x92 a read returns the coin status {6'b0, p2_n[7], p1_n[7]}.
- R3: Under 0x91 a read returns the credit count after that read's accounting. Accounting runs only when all of these hold: the status differs from the previous sample, the status is neither 3 nor 0, and credits are below 9. Every 0x91 read stores the status as the new previous sample.
- R4: When status bit 1 is set, the rate index is dip_sw[5:4]; when status bit 0 is set, it is dip_sw[7:6]. The index maps coins needed to credits given as follows: 0 gives 2 to 3, 1 gives 2 to 1, 2 gives 1 to 2, 3 gives 1 to 1. The coin count goes up by one, and once it reaches the number needed, that number is subtracted and the credits are added.
- R5: Credits never exceed 9. A sum above 9 is clamped to 9.
- R6: A read under 0xE0 clears the coin and credit counts and returns 0xFF.
- R7: A read under 0xE1 returns 0xFF and lowers credits by one. If credits are already 0, they stay at 0.
- R8: Under 0xFE a read returns {0000, dip_sw[3:0]}, and under 0xFF it returns {0000, dip_sw[7:4]}.
- R9: Each counted coin raises coin_pulse[k] for exactly one clock, where k is the set status bit. This happens whether or not credits were granted.
- R10: Any other command byte, and any read with no command written since reset, returns 0xFF. After reset rd_data is 0xFF, and the counts and the previous sample are 0.
- R11: rd_data is registered. It changes on the clock edge that samples rd_en and holds until the next read. If a write and a read fall in the same cycle, the read uses the previously latched command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Command write strobe |
| wr_data | input | 8 | Command byte |
| rd_en | input | 1 | Data read strobe |
| rd_data | output | 8 | Registered read data |
| p1_n | input | 8 | Player 1 controls, active low, bit 7 coin |
| p2_n | input | 8 | Player 2 controls, active low, bit 7 coin |
| dip_sw | input | 8 | DIP switch bank |
| coin_pulse | output | 2 | One-clock coin counter pulses, one per status bit |

## Verification
The bench goes after the places where the ledger can drift:
- Repeated credit reads with an unchanged status must count nothing. A design that detects level instead of change would mint a credit on every poll.
- Status 3 and status 0 must be ignored. Mishandling either would count coins while the switches are idle or stuck.
- At the ceiling, a further coin must give neither a credit nor a pulse. A design that only clamps would still pulse and would keep a stale coin.
- The two-coin rates must hold a coin in the count across reads. A design that tests before incrementing would need three coins.
- A decrement at zero must stay at zero and not wrap to fifteen.
- A same-cycle write and read must use the old command. Swapping the DIP fields between slots shows up as the wrong credit totals.

// File: rtl/ioc_pkg.sv
package ioc_pkg;

    typedef enum logic [3:0] {
        CMD_NONE,
        CMD_P1,
        CMD_P2,
        CMD_COINRAW,
        CMD_CREDIT,
        CMD_CLEAR,
        CMD_DEC,
        CMD_DIPLO,
        CMD_DIPHI
    } cmd_e;

    localparam logic [7:0] OP_P1      = 8'h81;
    localparam logic [7:0] OP_P2      = 8'h82;
    localparam logic [7:0] OP_CREDIT  = 8'h91;
    localparam logic [7:0] OP_COINRAW = 8'h92;
    localparam logic [7:0] OP_CLEAR   = 8'hE0;
    localparam logic [7:0] OP_DEC     = 8'hE1;
    localparam logic [7:0] OP_DIPLO   = 8'hFE;
    localparam logic [7:0] OP_DIPHI   = 8'hFF;

    // coins required before a grant, per rate index
    function automatic logic [1:0] rate_need(input logic [1:0] idx);
        case (idx)
            2'd0, 2'd1: rate_need = 2'd2;
            default:    rate_need = 2'd1;
        endcase
    endfunction

    // credits granted once the requirement is met
    function automatic logic [1:0] rate_give(input logic [1:0] idx);
        case (idx)
            2'd0:    rate_give = 2'd3;
            2'd2:    rate_give = 2'd2;
            default: rate_give = 2'd1;
        endcase
    endfunction

endpackage

// File: rtl/ioc_cmd_decode.sv
module ioc_cmd_decode
    import ioc_pkg::*;
(
    input  logic [7:0] op_byte,
    output cmd_e       cmd
);

    always_comb begin
        case (op_byte)
            OP_P1:      cmd = CMD_P1;
            OP_P2:      cmd = CMD_P2;
            OP_CREDIT:  cmd = CMD_CREDIT;
            OP_COINRAW: cmd = CMD_COINRAW;
            OP_CLEAR:   cmd = CMD_CLEAR;
            OP_DEC:     cmd = CMD_DEC;
            OP_DIPLO:   cmd = CMD_DIPLO;
            OP_DIPHI:   cmd = CMD_DIPHI;
            default:    cmd = CMD_NONE;
        endcase
    end

endmodule

// File: rtl/ioc_coin_acct.sv
module ioc_coin_acct
    import ioc_pkg::*;
#(
    parameter int SLOTS    = 2,
    parameter int CRED_W   = 4,
    parameter int COIN_W   = 2,
    parameter int CRED_MAX = 9
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 credit_rd,
    input  logic                 clear_rd,
    input  logic                 dec_rd,
    input  logic [SLOTS-1:0]     coin_stat,
    input  logic [2*SLOTS-1:0]   rate_sel,
    output logic [CRED_W-1:0]    credits_q,
    output logic [CRED_W-1:0]    credits_nx,
    output logic [SLOTS-1:0]     pulse_q
);

    localparam int SUM_W = CRED_W + 1;
    localparam int CS_W  = COIN_W + 1;

    logic [COIN_W-1:0] coins_q, coins_nx;
    logic [SLOTS-1:0]  prev_q;
    logic [SLOTS-1:0]  pulse_nx;
    logic [1:0]        need_s [SLOTS];
    logic [1:0]        give_s [SLOTS];

    // per-slot rate lookup
    for (genvar g = 0; g < SLOTS; g++) begin : g_rate
        assign need_s[g] = rate_need(rate_sel[2*g +: 2]);
        assign give_s[g] = rate_give(rate_sel[2*g +: 2]);
    end

    logic              take;
    logic [1:0]        need_sel, give_sel;
    logic [SLOTS-1:0]  slot_hot;
    logic [CS_W-1:0]   coin_sum;
    logic [SUM_W-1:0]  cred_sum;

    assign take = credit_rd && (coin_stat != prev_q) && !(&coin_stat)
               && (|coin_stat) && (credits_q < CRED_W'(CRED_MAX));

    always_comb begin
        need_sel = '0;
        give_sel = '0;
        slot_hot = '0;
        for (int s = 0; s < SLOTS; s++) begin
            if (coin_stat[s] && slot_hot == '0) begin
                need_sel    = need_s[s];
                give_sel    = give_s[s];
                slot_hot[s] = 1'b1;
            end
        end
    end

    always_comb begin
        coins_nx   = coins_q;
        credits_nx = credits_q;
        pulse_nx   = '0;
        coin_sum   = {1'b0, coins_q} + CS_W'(1);
        cred_sum   = {1'b0, credits_q} + {{(SUM_W-2){1'b0}}, give_sel};
        if (clear_rd) begin
            coins_nx   = '0;
            credits_nx = '0;
        end else if (dec_rd) begin
            if (credits_q != '0)
                credits_nx = credits_q - CRED_W'(1);
        end else if (take) begin
            pulse_nx = slot_hot;
            if (coin_sum >= {{(CS_W-2){1'b0}}, need_sel}) begin
                coins_nx = COIN_W'(coin_sum - {{(CS_W-2){1'b0}}, need_sel});
                if (cred_sum > SUM_W'(CRED_MAX))
                    credits_nx = CRED_W'(CRED_MAX);
                else
                    credits_nx = cred_sum[CRED_W-1:0];
            end else begin
                coins_nx = coin_sum[COIN_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            coins_q   <= '0;
            credits_q <= '0;
            prev_q    <= '0;
            pulse_q   <= '0;
        end else begin
            coins_q   <= coins_nx;
            credits_q <= credits_nx;
            pulse_q   <= pulse_nx;
            if (credit_rd)
                prev_q <= coin_stat;
        end
    end

endmodule

// File: rtl/ioc_read_mux.sv
module ioc_read_mux
    import ioc_pkg::*;
#(
    parameter int CRED_W = 4
) (
    input  cmd_e              cmd,
    input  logic [7:0]        p1_n,
    input  logic [7:0]        p2_n,
    input  logic [7:0]        dip_sw,
    input  logic [CRED_W-1:0] credits,
    output logic [7:0]        data
);

    always_comb begin
        unique case (cmd)
            CMD_P1:      data = {1'b0, p1_n[6:0]};
            CMD_P2:      data = {1'b0, p2_n[6:0]};
            CMD_COINRAW: data = {6'b0, p2_n[7], p1_n[7]};
            CMD_CREDIT:  data = {{(8-CRED_W){1'b0}}, credits};
            CMD_DIPLO:   data = {4'b0, dip_sw[3:0]};
            CMD_DIPHI:   data = {4'b0, dip_sw[7:4]};
            default:     data = 8'hFF;
        endcase
    end

endmodule

// File: rtl/coin_io_ctrl.sv
module coin_io_ctrl
    import ioc_pkg::*;
#(
    parameter int CRED_W   = 4,
    parameter int COIN_W   = 2,
    parameter int CRED_MAX = 9
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       rd_en,
    output logic [7:0] rd_data,
    input  logic [7:0] p1_n,
    input  logic [7:0] p2_n,
    input  logic [7:0] dip_sw,
    output logic [1:0] coin_pulse
);

    cmd_e              cmd_q;
    cmd_e              cmd_nx;
    logic [CRED_W-1:0] credits_q, credits_nx;
    logic [7:0]        mux_data;

    ioc_cmd_decode u_dec (
        .op_byte (wr_data),
        .cmd     (cmd_nx)
    );

    // state register: decoded command
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmd_q <= CMD_NONE;
        else if (wr_en)
            cmd_q <= cmd_nx;
    end

    ioc_coin_acct #(
        .SLOTS    (2),
        .CRED_W   (CRED_W),
        .COIN_W   (COIN_W),
        .CRED_MAX (CRED_MAX)
    ) u_acct (
        .clk        (clk),
        .rst_n      (rst_n),
        .credit_rd  (rd_en && cmd_q == CMD_CREDIT),
        .clear_rd   (rd_en && cmd_q == CMD_CLEAR),
        .dec_rd     (rd_en && cmd_q == CMD_DEC),
        .coin_stat  ({p2_n[7], p1_n[7]}),
        .rate_sel   ({dip_sw[5:4], dip_sw[7:6]}),
        .credits_q  (credits_q),
        .credits_nx (credits_nx),
        .pulse_q    (coin_pulse)
    );

    ioc_read_mux #(.CRED_W(CRED_W)) u_mux (
        .cmd     (cmd_q),
        .p1_n    (p1_n),
        .p2_n    (p2_n),
        .dip_sw  (dip_sw),
        .credits (credits_nx),
        .data    (mux_data)
    );

    // output process: registered read data
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= 8'hFF;
        else if (rd_en)
            rd_data <= mux_data;
    end

endmodule

// File: rtl/ioc_checker.sv
module ioc_checker
    import ioc_pkg::*;
#(
    parameter int CRED_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en,
    input cmd_e              cmd,
    input logic [7:0]        p1_n,
    input logic [7:0]        dip_sw,
    input logic [7:0]        rd_data,
    input logic [1:0]        coin_pulse,
    input logic [CRED_W-1:0] credits
);

    a_r1_p1_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && cmd == CMD_P1 |=> rd_data == {1'b0, $past(p1_n[6:0])});

    a_r3_credit_echo: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && cmd == CMD_CREDIT |=> rd_data == {{(8-CRED_W){1'b0}}, credits});

    a_r5_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && cmd == CMD_CREDIT |=> rd_data <= 8'd9);

    a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && cmd == CMD_CLEAR |=> rd_data == 8'hFF && credits == '0);

    a_r8_dip_high: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && cmd == CMD_DIPHI |=> rd_data == {4'b0, $past(dip_sw[7:4])});

    a_r9_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(coin_pulse));

    a_r9_short_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        coin_pulse[0] |=> !coin_pulse[0]);

    a_r10_unknown: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && cmd == CMD_NONE |=> rd_data == 8'hFF);

    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en && $past(rst_n) |=> $stable(rd_data));

endmodule

bind coin_io_ctrl ioc_checker #(.CRED_W(CRED_W)) u_ioc_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en      (rd_en),
    .cmd        (cmd_q),
    .p1_n       (p1_n),
    .dip_sw     (dip_sw),
    .rd_data    (rd_data),
    .coin_pulse (coin_pulse),
    .credits    (credits_q)
);

// File: tb/tb_coin_io_ctrl.sv
module tb_coin_io_ctrl;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en, rd_en;
    logic [7:0] wr_data, rd_data, p1_n, p2_n, dip_sw;
    logic [1:0] coin_pulse;

    always #2 clk = ~clk;

    coin_io_ctrl dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .p1_n(p1_n), .p2_n(p2_n),
        .dip_sw(dip_sw), .coin_pulse(coin_pulse)
    );

    int n_cmp = 0, n_bad = 0;
    bit done = 0;
    int m_cmd = -1, m_coins = 0, m_cred = 0, m_prev = 0;
    int exp_rd = 255, exp_pulse = 0;

    function automatic int need_of(int i);
        return (i < 2) ? 2 : 1;
    endfunction
    function automatic int give_of(int i);
        case (i) 0: return 3; 2: return 2; default: return 1; endcase
    endfunction

    task automatic model_read();
        int st, slot, idx;
        st = {p2_n[7], p1_n[7]};
        case (m_cmd)
            8'h81: exp_rd = p1_n & 8'h7F;
            8'h82: exp_rd = p2_n & 8'h7F;
            8'h92: exp_rd = st;
            8'h91: begin
                if (st != m_prev && st != 3 && st != 0 && m_cred < 9) begin
                    slot = (st == 2) ? 1 : 0;
                    idx  = slot ? int'(dip_sw[5:4]) : int'(dip_sw[7:6]);
                    m_coins++;
                    if (m_coins >= need_of(idx)) begin
                        m_cred  += give_of(idx);
                        m_coins -= need_of(idx);
                    end
                    if (m_cred > 9) m_cred = 9;
                    exp_pulse = 1 << slot;
                end
                m_prev = st;
                exp_rd = m_cred;
            end
            8'hE0: begin m_coins = 0; m_cred = 0; exp_rd = 255; end
            8'hE1: begin if (m_cred > 0) m_cred--; exp_rd = 255; end
            8'hFE: exp_rd = dip_sw & 8'h0F;
            8'hFF: exp_rd = dip_sw >> 4;
            default: exp_rd = 255;
        endcase
    endtask

    task automatic check(string tag);
        n_cmp++;
        if (rd_data !== 8'(exp_rd)) begin
            n_bad++;
            $display("FAIL %s rd_data actual=%02h expected=%02h", tag, rd_data, 8'(exp_rd));
        end
        n_cmp++;
        if (coin_pulse !== 2'(exp_pulse)) begin
            n_bad++;
            $display("FAIL R9 coin_pulse actual=%b expected=%b (%s)", coin_pulse, 2'(exp_pulse), tag);
        end
    endtask

    // one clock: inputs set at negedge, model at posedge, compare at next negedge
    task automatic step(bit wr, logic [7:0] wd, bit rd, string tag);
        wr_en = wr; wr_data = wd; rd_en = rd;
        @(posedge clk);
        exp_pulse = 0;
        if (rd) model_read();
        if (wr) m_cmd = wd;
        @(negedge clk);
        wr_en = 0; rd_en = 0;
        check(tag);
    endtask

    task automatic cmd(logic [7:0] b, string tag);
        step(1, b, 0, tag);
    endtask
    task automatic rd(string tag);
        step(0, 8'h00, 1, tag);
    endtask
    task automatic coin(int st, string tag);
        p1_n[7] = st[0]; p2_n[7] = st[1];
        rd(tag);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 0; wr_en = 0; rd_en = 0; wr_data = 0;
        p1_n = 8'hFF; p2_n = 8'hFF; dip_sw = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1;
        check("R10 reset");
        rd("R10 no command");

        // R1 player reads
        cmd(8'h81, "R1");
        p1_n = 8'hA5; rd("R1 p1");
        p1_n = 8'hFF; rd("R1 p1 bit7 zero");
        cmd(8'h82, "R1");
        p2_n = 8'h3C; rd("R1 p2");
        // R11 same-cycle write and read uses old command
        p1_n = 8'hC3;
        step(1, 8'hFE, 1, "R11 same cycle");
        step(0, 8'h00, 0, "R11 hold");
        // R2 raw coin status
        cmd(8'h92, "R2");
        p1_n = 8'h7F; p2_n = 8'hFF; rd("R2 status 2");
        p1_n = 8'hFF; p2_n = 8'h7F; rd("R2 status 1");
        p2_n = 8'hFF;
        // R8 DIP nibbles
        dip_sw = 8'h5A;
        cmd(8'hFE, "R8"); rd("R8 low");
        cmd(8'hFF, "R8"); rd("R8 high");
        // R10 unknown commands
        cmd(8'h00, "R10"); rd("R10 cmd 00");
        cmd(8'h93, "R10"); rd("R10 cmd 93");

        // R4 rates: bit1 idx3 (1->1), bit0 idx0 (2->3)
        dip_sw = 8'h3F;
        cmd(8'hE0, "R6"); rd("R6 clear");
        cmd(8'h91, "R3");
        coin(3, "R3 idle status");
        coin(2, "R4 bit1 coin");
        coin(2, "R3 no change");
        coin(3, "R3 release");
        coin(1, "R4 bit0 first coin");
        coin(3, "R3 release");
        coin(1, "R4 bit0 second coin");
        coin(0, "R3 status zero");
        coin(3, "R3 release");
        for (int i = 0; i < 6; i++) begin
            coin(2, "R5 fill");
            coin(3, "R5 release");
        end
        coin(1, "R5 at ceiling");
        coin(3, "R5 release");
        cmd(8'hE1, "R7"); rd("R7 decrement");
        cmd(8'h91, "R3"); rd("R3 after dec");
        // second rate set: bit0 idx2 (1->2), bit1 idx1 (2->1)
        dip_sw = 8'h9F;
        cmd(8'hE0, "R6"); rd("R6 clear");
        cmd(8'hE1, "R7"); rd("R7 dec at zero");
        cmd(8'h91, "R3");
        coin(1, "R4 idx2");
        coin(3, "R3 release");
        coin(2, "R4 idx1 first");
        coin(1, "R4 alternate slot");
        coin(2, "R4 idx1 second");
        coin(3, "R3 release");

        // mixed traffic
        for (int i = 0; i < 600; i++) begin
            logic [7:0] ops [10] = '{8'h81, 8'h82, 8'h91, 8'h91, 8'h91,
                                     8'h92, 8'hE0, 8'hE1, 8'hFE, 8'h37};
            int k;
            k = $urandom_range(0, 9);
            if ($urandom_range(0, 3) == 0) begin
                dip_sw = 8'($urandom);
                cmd(ops[k], "R4 mixed");
            end
            p1_n = 8'($urandom); p2_n = 8'($urandom);
            step($urandom_range(0, 5) == 0, ops[$urandom_range(0, 9)],
                 1'b1, "R3 mixed");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule